// File: doc/BRIEF.md
# Fully Associative Write-Back Data Cache

This block is a small data cache that sits between a processor port one word wide and a memory port one block wide. The cache has no set index. Every line belongs to a single set, and each lookup compares the request tag against all valid lines at once. A hit returns the selected word in the same cycle. A hit write changes only the cached copy and marks the line dirty.

On a miss, the controller picks a victim line. It takes the lowest-numbered invalid line if one exists, and otherwise the line named by a round-robin pointer. If the victim is dirty, its block is first written back to memory. The requested block is then fetched. A write miss allocates the block and merges the written word into it afterwards. The processor holds its request steady until `cpu_done` is high for one cycle. It sees `cpu_stall` while a miss is in progress.

Top module: `fa_wb_cache`

## Requirements
- R1: After reset no line is valid, so the first access to any address misses. While idle, `cpu_stall`, `cpu_done` and `mem_req` are low.
- R2: A read hit raises `cpu_done` in the same cycle the request is presented, with no memory request. `cpu_rdata` returns the word chosen by address bits [3:2], where value k selects word k and word k sits in bits [32k+31:32k] of a block.
- R3: A read miss fetches one block from `mem_addr` equal to the request address with bits [3:0] cleared and `mem_we` low. It then returns the selected word of that block.
- R4: A write hit changes only the cached word and makes no memory request. A later read of that address returns the written value.
- R5: A write miss first fetches the block and then merges the written word. The other words of the line keep the values fetched from memory.
- R6: Evicting a dirty line first writes its whole block, with `mem_we` high, to the address formed by its tag with bits [3:0] zero. The block includes every earlier write. The refill follows.
- R7: Evicting a clean line makes no write to memory.
- R8: Victim choice takes the lowest-numbered invalid line. When all lines are valid, it takes the line named by a round-robin pointer that starts at 0 and advances by one on every refill. Lines are therefore evicted in refill order.
- R9: `cpu_stall` is high from the cycle a miss is detected until the cycle `cpu_done` is given. `cpu_done` and `cpu_stall` are never high together.
- R10: `mem_req` stays high until `mem_ready` is seen high at a clock edge, and one block moves per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_done` |
| cpu_done | output | 1 | Access complete this cycle |
| cpu_stall | output | 1 | Miss in progress |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wblock | output | 128 | Block written back |
| mem_rblock | input | 128 | Block returned on refill |
| mem_ready | input | 1 | Transfer accepted at this edge |

## Verification
The hardest case to reach is a dirty eviction chosen by the round-robin pointer. It needs every line filled, at least one line made dirty, and the pointer wrapped to that line. The bench makes one line dirty with a write hit and another with a write miss. It fills the remaining lines with reads of distinct blocks. Two further misses must then write back those two blocks in refill order. A third miss then hits a clean victim. Reading the evicted address back through a fresh refill shows that the written-back data reached memory.

// File: rtl/fa_cache_pkg.sv
// Shared types for the fully associative cache.
// Assumes: one outstanding processor access at a time.
package fa_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2,
        ST_UPD  = 2'd3
    } fa_state_t;
endpackage

// File: rtl/fa_tag_store.sv
// Tag, valid and dirty bits for every line, plus the parallel tag compare.
// Assumes: fill and dirty-set never target the same line in one cycle.
module fa_tag_store #(
    parameter int LINES = 8,
    parameter int TAG_W = 28,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             dirty_en,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic [IDX_W-1:0] vic_idx,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [LINES-1:0] valid_vec,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] dirty_q;
    logic [LINES-1:0] match;

    // One comparator per line.
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_cmp
            assign match[g] = valid_vec[g] && (tag_q[g] == lk_tag);
        end
    endgenerate

    // Encode the matching line number.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LINES; i++)
            if (match[i]) hit_idx = IDX_W'(i);
    end
    assign hit       = |match;
    assign vic_dirty = dirty_q[vic_idx] && valid_vec[vic_idx];
    assign vic_tag   = tag_q[vic_idx];

    // Update valid/dirty state; a fill leaves the line valid and clean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
            dirty_q   <= '0;
        end else begin
            if (fill_en) begin
                valid_vec[fill_idx] <= 1'b1;
                dirty_q[fill_idx]   <= 1'b0;
            end
            if (dirty_en) dirty_q[dirty_idx] <= 1'b1;
        end
    end

    // Store the tag of a refilled line.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx] <= lk_tag;
    end

    // Tags in the cache are unique, so at most one line can match.
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/fa_victim_sel.sv
// Picks the replacement line: lowest invalid line, otherwise the round-robin pointer.
// Assumes: advance pulses once per completed refill.
module fa_victim_sel #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] valid_vec,
    input  logic             advance,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr_q;

    // Lowest-numbered invalid line wins; fall back to the pointer.
    always_comb begin
        victim = rr_q;
        for (int i = LINES - 1; i >= 0; i--)
            if (!valid_vec[i]) victim = IDX_W'(i);
    end

    // Step the pointer on every refill.
    always_ff @(posedge clk) begin
        if (!rst_n)       rr_q <= '0;
        else if (advance) rr_q <= rr_q + 1'b1;
    end
endmodule

// File: rtl/fa_miss_ctrl.sv
// Miss sequencer: IDLE, optional write-back, refill, then update/deliver.
// Assumes: the processor holds its request stable until done.
module fa_miss_ctrl
    import fa_cache_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_req,
    input  logic      hit,
    input  logic      vic_dirty,
    input  logic      mem_ready,
    output fa_state_t state,
    output logic      miss_start,
    output logic      fill_fire,
    output logic      mem_req,
    output logic      mem_we
);
    fa_state_t nxt;

    // Next-state choice.
    always_comb begin
        nxt        = state;
        miss_start = 1'b0;
        unique case (state)
            ST_IDLE: if (cpu_req && !hit) begin
                miss_start = 1'b1;
                nxt        = vic_dirty ? ST_WB : ST_FILL;
            end
            ST_WB:   if (mem_ready) nxt = ST_FILL;
            ST_FILL: if (mem_ready) nxt = ST_UPD;
            ST_UPD:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign mem_req   = (state == ST_WB) || (state == ST_FILL);
    assign mem_we    = (state == ST_WB);
    assign fill_fire = (state == ST_FILL) && mem_ready;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)));
    a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));
endmodule

// File: rtl/fa_wb_cache.sv
// Fully associative write-back, write-allocate data cache.
// Assumes: one access at a time, held until cpu_done; memory moves whole blocks.
module fa_wb_cache
    import fa_cache_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32,
    localparam int OFF_W = $clog2(WORDS * WORD_W / 8),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BSEL_W = $clog2(WORD_W / 8),
    localparam int TAG_W = ADDR_W - OFF_W,
    localparam int IDX_W = $clog2(LINES),
    localparam int BLK_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wblock,
    input  logic [BLK_W-1:0]  mem_rblock,
    input  logic              mem_ready
);
    fa_state_t         state;
    logic              hit, vic_dirty, miss_start, fill_fire;
    logic [IDX_W-1:0]  hit_idx, vic_comb, vict_q, vic_idx, line_sel;
    logic [LINES-1:0]  valid_vec;
    logic [TAG_W-1:0]  req_tag, vic_tag;
    logic [WSEL_W-1:0] wsel;
    logic              wr_hit, wr_upd;
    logic [BLK_W-1:0]  line_data [LINES];

    assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
    assign wsel    = cpu_addr[BSEL_W +: WSEL_W];
    assign vic_idx = (state == ST_IDLE) ? vic_comb : vict_q;

    fa_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_tag(req_tag),
        .fill_en(fill_fire), .fill_idx(vict_q),
        .dirty_en(wr_hit || wr_upd), .dirty_idx(line_sel),
        .vic_idx(vic_idx), .hit(hit), .hit_idx(hit_idx),
        .valid_vec(valid_vec), .vic_dirty(vic_dirty), .vic_tag(vic_tag)
    );

    fa_victim_sel #(.LINES(LINES)) u_vic (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
        .advance(fill_fire), .victim(vic_comb)
    );

    fa_miss_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .hit(hit),
        .vic_dirty(vic_dirty), .mem_ready(mem_ready), .state(state),
        .miss_start(miss_start), .fill_fire(fill_fire),
        .mem_req(mem_req), .mem_we(mem_we)
    );

    // Hold the chosen victim for the whole miss.
    always_ff @(posedge clk) begin
        if (!rst_n)          vict_q <= '0;
        else if (miss_start) vict_q <= vic_comb;
    end

    assign line_sel = (state == ST_UPD) ? vict_q : hit_idx;
    assign wr_hit   = (state == ST_IDLE) && cpu_req && cpu_we && hit;
    assign wr_upd   = (state == ST_UPD) && cpu_we;

    // Data array: block refill, or a word merge on a write hit / after allocate.
    always_ff @(posedge clk) begin
        if (fill_fire)
            line_data[vict_q] <= mem_rblock;
        else if (wr_hit || wr_upd)
            line_data[line_sel][wsel*WORD_W +: WORD_W] <= cpu_wdata;
    end

    assign cpu_rdata  = line_data[line_sel][wsel*WORD_W +: WORD_W];
    assign cpu_done   = ((state == ST_IDLE) && cpu_req && hit) || (state == ST_UPD);
    assign cpu_stall  = ((state == ST_IDLE) && cpu_req && !hit) ||
                        (state == ST_WB) || (state == ST_FILL);
    assign mem_addr   = mem_we ? {vic_tag, {OFF_W{1'b0}}} : {req_tag, {OFF_W{1'b0}}};
    assign mem_wblock = line_data[vict_q];

    a_r9_done_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_done && cpu_stall));
    a_r4_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && hit) |-> !mem_req);
    a_r7_clean_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_start && !vic_dirty) |=> (mem_req && !mem_we));
    a_r3_fill_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire |=> cpu_done);
endmodule

// File: tb/sim_fa_wb_cache.sv
module sim_fa_wb_cache;
    logic         clk = 0, rst_n = 0;
    logic         cpu_req = 0, cpu_we = 0;
    logic [31:0]  cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
    logic         cpu_done, cpu_stall, mem_req, mem_we, mem_ready = 0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wblock, mem_rblock = 0;
    logic [127:0] mem [64];
    int checks = 0, fails = 0, rd_cnt = 0, wb_cnt = 0, cyc = 0;
    logic [31:0]  last_rd, last_wb;
    logic [31:0]  rdv;
    int           lat;
    logic         stall_seen;

    always #5 clk = ~clk;

    fa_wb_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wblock(mem_wblock),
        .mem_rblock(mem_rblock), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] pat(int blk, int w);
        return 32'hA000_0000 | (blk << 8) | w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: answers a request two cycles after it appears.
    initial begin
        int wait_n = 0;
        for (int b = 0; b < 64; b++)
            for (int w = 0; w < 4; w++) mem[b][w*32 +: 32] = pat(b, w);
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 0; wait_n = 0;
            end else if (mem_req && rst_n) begin
                wait_n++;
                if (wait_n == 2) begin
                    if (mem_we) begin
                        mem[mem_addr[9:4]] = mem_wblock; wb_cnt++; last_wb = mem_addr;
                    end else begin
                        mem_rblock = mem[mem_addr[9:4]]; rd_cnt++; last_rd = mem_addr;
                    end
                    mem_ready = 1;
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // One access; result in rdv, waited cycles in lat.
    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        lat = 0; stall_seen = 0;
        #1;
        while (!cpu_done) begin
            if (cpu_stall) stall_seen = 1;
            @(negedge clk); #1; lat++;
        end
        rdv = cpu_rdata;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic t_reset;
        chk(!cpu_stall && !cpu_done && !mem_req, "R1 idle outputs", {29'd0, cpu_stall, cpu_done, mem_req}, 0);
    endtask

    task automatic t_read_miss;
        access(0, 32'h018, 0);
        chk(rdv == pat(1, 2), "R3 read miss data", rdv, pat(1, 2));
        chk(rd_cnt == 1 && last_rd == 32'h010, "R3 refill addr", last_rd, 32'h010);
        chk(lat > 0, "R1 first access misses", lat, 1);
        chk(stall_seen, "R9 stall during miss", stall_seen, 1);
        chk(wb_cnt == 0, "R7 no writeback into empty", wb_cnt, 0);
    endtask

    task automatic t_read_hit;
        access(0, 32'h01C, 0);
        chk(rdv == pat(1, 3) && lat == 0, "R2 read hit word 3", rdv, pat(1, 3));
        access(0, 32'h010, 0);
        chk(rdv == pat(1, 0) && lat == 0 && rd_cnt == 1, "R2 read hit word 0", rdv, pat(1, 0));
    endtask

    task automatic t_write_hit;
        access(1, 32'h014, 32'hDEAD_0001);
        chk(lat == 0 && rd_cnt == 1 && wb_cnt == 0, "R4 write hit no mem", lat, 0);
        chk(mem[1][63:32] == pat(1, 1), "R4 memory unchanged", mem[1][63:32], pat(1, 1));
        access(0, 32'h014, 0);
        chk(rdv == 32'hDEAD_0001, "R4 readback", rdv, 32'hDEAD_0001);
    endtask

    task automatic t_write_miss;
        access(1, 32'h108, 32'hBEEF_0002);
        chk(rd_cnt == 2 && last_rd == 32'h100 && wb_cnt == 0, "R5 allocate refill", last_rd, 32'h100);
        access(0, 32'h108, 0);
        chk(rdv == 32'hBEEF_0002 && lat == 0, "R5 merged word", rdv, 32'hBEEF_0002);
        access(0, 32'h104, 0);
        chk(rdv == pat(16, 1), "R5 other word kept", rdv, pat(16, 1));
    endtask

    task automatic t_evict;
        for (int b = 2; b < 8; b++) access(0, b * 16, 0);
        chk(rd_cnt == 8 && wb_cnt == 0, "R8 invalid lines used first", wb_cnt, 0);
        access(0, 32'h080, 0);
        chk(wb_cnt == 1 && last_wb == 32'h010, "R6 dirty victim written back", last_wb, 32'h010);
        chk(mem[1][63:32] == 32'hDEAD_0001, "R6 writeback data", mem[1][63:32], 32'hDEAD_0001);
        chk(rdv == pat(8, 0), "R3 data after eviction", rdv, pat(8, 0));
        access(0, 32'h014, 0);
        chk(lat > 0 && rdv == 32'hDEAD_0001, "R6 data back from memory", rdv, 32'hDEAD_0001);
        chk(wb_cnt == 2 && last_wb == 32'h100, "R8 round-robin second victim", last_wb, 32'h100);
        chk(mem[16][95:64] == 32'hBEEF_0002, "R6 allocated word written back", mem[16][95:64], 32'hBEEF_0002);
        access(0, 32'h090, 0);
        chk(wb_cnt == 2 && rd_cnt == 11, "R7 clean eviction no write", wb_cnt, 2);
        access(0, 32'h030, 0);
        chk(lat == 0, "R8 line 3 still resident", lat, 0);
        access(0, 32'h020, 0);
        chk(lat > 0, "R8 line 2 was evicted", lat, 1);
        chk(!mem_req && !cpu_stall, "R10 memory idle after miss", mem_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_evict();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule